// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block decides whether a set of pending interrupt requests is urgent enough to interrupt the processor. It takes two request sources. The first is a software request word, in which a contiguous run of bits each stands for one software priority level. The second is a small group of external interrupt lines, and each line carries a fixed level that sits above every software level. The block finds the highest level that is pending and compares it with the current processor priority level. When the pending level is strictly higher, it emits a one-cycle trap request. On that same edge it latches a summary word of every pending request bit and an identifier that holds the winning level.

Evaluation is not continuous. A check strobe arms a pending-check flag, and the evaluation that follows consumes the flag. The surrounding core therefore decides when interrupts are looked at, for example after the priority level is lowered or a return from an exception. The summary and identifier registers keep their last trap's contents until the next trap that is taken.

Top module: `ila_arbiter`

## Requirements
- R1: While `rst_n` is low and right after it is released, `trap_o` is 0, `isr_o` is 0 and `intid_o` is 0, and no check is pending.
- R2: Software request bit 4+n (n = 0..14) of `sw_req_i` stands for level n+1. When several such bits are set, the highest set bit gives the software level.
- R3: Bits 0..3 and 19..23 of `sw_req_i` are ignored. They add no level and no summary bit.
- R4: External line k of `ext_irq_i` (k = 0..3) stands for level 20+k. The highest set line wins, and any set line outranks every software request.
- R5: The summary value holds every valid pending request at its own bit position: software bits at positions 4..18 of `sw_req_i`, and external line k at position 20+k. All other bits are 0.
- R6: A trap is taken only when the winning level is nonzero and strictly greater than `cur_ipl_i`. A level equal to or below `cur_ipl_i` takes no trap.
- R7: When a trap is taken, `isr_o` gets the summary value and `intid_o` gets the winning level, on the same edge that raises `trap_o`. Otherwise both keep their values.
- R8: An evaluation happens only at the rising edge after the one that sampled `check_req_i` high, and that evaluation clears the flag. Without a strobe, input changes have no effect. A strobe held for n cycles gives n back-to-back evaluations.
- R9: `trap_o` is high for exactly one cycle per evaluation that takes a trap. It becomes visible after the second rising edge that follows the strobe being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_req_i | input | 24 | Software request word; bits 4..18 are request levels |
| ext_irq_i | input | 4 | External interrupt lines, line k is level 20+k |
| cur_ipl_i | input | 5 | Current processor priority level |
| check_req_i | input | 1 | Strobe that arms one evaluation |
| trap_o | output | 1 | One-cycle interrupt trap request |
| isr_o | output | 24 | Latched summary of pending request bits |
| intid_o | output | 5 | Latched winning level |

## Verification
The scan is tried with several patterns, each aimed at one kind of error:
- A single lowest or highest software bit, and multi-bit software words, catch an off-by-one in the bit-to-level map and a wrong scan direction.
- Words that set only out-of-range bits show whether the field mask leaks.
- Mixed software and external requests show whether external lines win and land at the right summary positions.
- Priority levels equal to, one below and above the pending level separate a strict compare from a loose one.
- Dropping the strobe, or holding it for two cycles, shows whether evaluation is tied to the pending flag and not to the inputs.

// File: rtl/ila_pkg.sv
package ila_pkg;
   // default geometry of the request word and level field
   localparam int DEF_SUM_W   = 24;
   localparam int DEF_SW_LO   = 4;
   localparam int DEF_SW_NUM  = 15;
   localparam int DEF_EXT_LO  = 20;
   localparam int DEF_EXT_NUM = 4;
   localparam int DEF_LVL_W   = 5;
endpackage

// File: rtl/ila_sw_encoder.sv
module ila_sw_encoder #(
   parameter int SUM_W  = ila_pkg::DEF_SUM_W,
   parameter int SW_LO  = ila_pkg::DEF_SW_LO,
   parameter int SW_NUM = ila_pkg::DEF_SW_NUM,
   parameter int LVL_W  = ila_pkg::DEF_LVL_W
) (
   input  logic [SUM_W-1:0] sw_req_i,
   output logic [LVL_W-1:0] sw_lvl_o,
   output logic [SUM_W-1:0] sw_sum_o
);
   localparam logic [SUM_W-1:0] SW_MASK =
      SUM_W'(((64'd1 << SW_NUM) - 64'd1) << SW_LO);

   logic unused_sw_bits;
   assign unused_sw_bits = ^(sw_req_i & ~SW_MASK);

   // ascending scan: the last set bit seen is the highest one
   always_comb begin
      sw_lvl_o = '0;
      for (int i = 0; i < SW_NUM; i++) begin
         if (sw_req_i[SW_LO + i]) sw_lvl_o = LVL_W'(i + 1);
      end
   end

   assign sw_sum_o = sw_req_i & SW_MASK;
endmodule

// File: rtl/ila_ext_encoder.sv
module ila_ext_encoder #(
   parameter int SUM_W   = ila_pkg::DEF_SUM_W,
   parameter int EXT_LO  = ila_pkg::DEF_EXT_LO,
   parameter int EXT_NUM = ila_pkg::DEF_EXT_NUM,
   parameter int LVL_W   = ila_pkg::DEF_LVL_W
) (
   input  logic [EXT_NUM-1:0] ext_irq_i,
   output logic [LVL_W-1:0]   ext_lvl_o,
   output logic [SUM_W-1:0]   ext_sum_o
);
   always_comb begin
      ext_lvl_o = '0;
      ext_sum_o = '0;
      for (int k = 0; k < EXT_NUM; k++) begin
         if (ext_irq_i[k]) begin
            ext_lvl_o            = LVL_W'(EXT_LO + k);
            ext_sum_o[EXT_LO + k] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/ila_trap_unit.sv
module ila_trap_unit #(
   parameter int SUM_W = ila_pkg::DEF_SUM_W,
   parameter int LVL_W = ila_pkg::DEF_LVL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             check_req_i,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic [SUM_W-1:0] sum_i,
   input  logic [LVL_W-1:0] cur_ipl_i,
   output logic             trap_o,
   output logic [SUM_W-1:0] isr_o,
   output logic [LVL_W-1:0] intid_o
);
   logic check_pend_q;
   logic fire;

   assign fire = check_pend_q && (lvl_i != '0) && (lvl_i > cur_ipl_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         check_pend_q <= 1'b0;
         trap_o       <= 1'b0;
         isr_o        <= '0;
         intid_o      <= '0;
      end else begin
         // evaluation consumes the flag; a new strobe re-arms it
         check_pend_q <= check_req_i;
         trap_o       <= fire;
         if (fire) begin
            isr_o   <= sum_i;
            intid_o <= lvl_i;
         end
      end
   end
endmodule

// File: rtl/ila_arbiter.sv
module ila_arbiter #(
   parameter int SUM_W   = ila_pkg::DEF_SUM_W,
   parameter int SW_LO   = ila_pkg::DEF_SW_LO,
   parameter int SW_NUM  = ila_pkg::DEF_SW_NUM,
   parameter int EXT_LO  = ila_pkg::DEF_EXT_LO,
   parameter int EXT_NUM = ila_pkg::DEF_EXT_NUM,
   parameter int LVL_W   = ila_pkg::DEF_LVL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SUM_W-1:0]   sw_req_i,
   input  logic [EXT_NUM-1:0] ext_irq_i,
   input  logic [LVL_W-1:0]   cur_ipl_i,
   input  logic               check_req_i,
   output logic               trap_o,
   output logic [SUM_W-1:0]   isr_o,
   output logic [LVL_W-1:0]   intid_o
);
   localparam int SW_TOP  = SW_LO + SW_NUM;
   localparam int EXT_TOP = EXT_LO + EXT_NUM;

   if (SW_NUM < 1 || EXT_NUM < 1) begin : g_bad_count
      $error("ila_arbiter: request ranges must be non-empty");
   end
   if (SW_TOP > EXT_LO) begin : g_bad_overlap
      $error("ila_arbiter: software range overlaps external range");
   end
   if (EXT_TOP > SUM_W) begin : g_bad_width
      $error("ila_arbiter: external range exceeds summary width");
   end
   if (EXT_TOP - 1 >= (1 << LVL_W)) begin : g_bad_lvl
      $error("ila_arbiter: level field too narrow");
   end

   logic [LVL_W-1:0] sw_lvl, ext_lvl, win_lvl;
   logic [SUM_W-1:0] sw_sum, ext_sum;

   ila_sw_encoder #(
      .SUM_W(SUM_W), .SW_LO(SW_LO), .SW_NUM(SW_NUM), .LVL_W(LVL_W)
   ) u_sw (
      .sw_req_i(sw_req_i), .sw_lvl_o(sw_lvl), .sw_sum_o(sw_sum)
   );

   ila_ext_encoder #(
      .SUM_W(SUM_W), .EXT_LO(EXT_LO), .EXT_NUM(EXT_NUM), .LVL_W(LVL_W)
   ) u_ext (
      .ext_irq_i(ext_irq_i), .ext_lvl_o(ext_lvl), .ext_sum_o(ext_sum)
   );

   // external lines are scanned after the software range
   assign win_lvl = (ext_lvl != '0) ? ext_lvl : sw_lvl;

   ila_trap_unit #(
      .SUM_W(SUM_W), .LVL_W(LVL_W)
   ) u_trap (
      .clk(clk), .rst_n(rst_n), .check_req_i(check_req_i),
      .lvl_i(win_lvl), .sum_i(sw_sum | ext_sum), .cur_ipl_i(cur_ipl_i),
      .trap_o(trap_o), .isr_o(isr_o), .intid_o(intid_o)
   );
endmodule

// File: rtl/ila_arbiter_chk.sv
module ila_arbiter_chk #(
   parameter int SUM_W   = ila_pkg::DEF_SUM_W,
   parameter int EXT_LO  = ila_pkg::DEF_EXT_LO,
   parameter int EXT_NUM = ila_pkg::DEF_EXT_NUM,
   parameter int LVL_W   = ila_pkg::DEF_LVL_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic [EXT_NUM-1:0] ext_irq_i,
   input logic [LVL_W-1:0]   cur_ipl_i,
   input logic               check_req_i,
   input logic               trap_o,
   input logic [SUM_W-1:0]   isr_o,
   input logic [LVL_W-1:0]   intid_o
);
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (trap_o == 1'b0 && isr_o == '0 && intid_o == '0));

   a_r2_id_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (intid_o != '0));

   a_r4_ext_outranks: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_o && ($past(ext_irq_i) != '0)) |-> (intid_o >= LVL_W'(EXT_LO)));

   a_r6_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (intid_o > $past(cur_ipl_i)));

   a_r7_hold_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_o |-> ($stable(isr_o) && $stable(intid_o)));

   a_r8_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> $past(check_req_i, 2));
endmodule

bind ila_arbiter ila_arbiter_chk #(
   .SUM_W(SUM_W), .EXT_LO(EXT_LO), .EXT_NUM(EXT_NUM), .LVL_W(LVL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq_i), .cur_ipl_i(cur_ipl_i),
   .check_req_i(check_req_i), .trap_o(trap_o), .isr_o(isr_o),
   .intid_o(intid_o)
);

// File: tb/test_ila_arbiter.sv
module test_ila_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 12;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [23:0] sw_req;
   logic [3:0]  ext_irq;
   logic [4:0]  cur_ipl;
   logic        check_req;
   logic        trap;
   logic [23:0] isr;
   logic [4:0]  intid;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ila_arbiter i_ila_arbiter (
      .clk(clk), .rst_n(rst_n), .sw_req_i(sw_req), .ext_irq_i(ext_irq),
      .cur_ipl_i(cur_ipl), .check_req_i(check_req), .trap_o(trap),
      .isr_o(isr), .intid_o(intid)
   );

   // {sw[62:39], ext[38:35], ipl[34:30], trap[29], id[28:24], isr[23:0]}
   localparam logic [62:0] VEC [NV] = '{
      {24'h000010, 4'h0, 5'd0,  1'b1, 5'd1,  24'h000010}, // R2 lowest bit
      {24'h040000, 4'h0, 5'd0,  1'b1, 5'd15, 24'h040000}, // R2 highest bit
      {24'h000110, 4'h0, 5'd3,  1'b1, 5'd5,  24'h000110}, // R2 R5 multi
      {24'h000100, 4'h0, 5'd5,  1'b0, 5'd5,  24'h000110}, // R6 equal, R7 hold
      {24'h88000F, 4'h0, 5'd0,  1'b0, 5'd5,  24'h000110}, // R3 out of range
      {24'h000000, 4'h1, 5'd0,  1'b1, 5'd20, 24'h100000}, // R4 line 0
      {24'h040010, 4'hA, 5'd22, 1'b1, 5'd23, 24'hA40010}, // R4 R5 mixed
      {24'h040000, 4'h4, 5'd22, 1'b0, 5'd23, 24'hA40010}, // R6 equal ext
      {24'h000020, 4'h0, 5'd1,  1'b1, 5'd2,  24'h000020}, // R6 one above
      {24'h07FFF0, 4'hF, 5'd31, 1'b0, 5'd2,  24'h000020}, // R6 below ipl
      {24'h07FFF0, 4'h0, 5'd14, 1'b1, 5'd15, 24'h07FFF0}, // R2 R5 full sw
      {24'hFFFFFF, 4'h0, 5'd0,  1'b1, 5'd15, 24'h07FFF0}  // R3 R5 all ones
   };

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // strobe at a falling edge; result visible after the second rising edge
   task automatic evaluate(input logic [23:0] sw, input logic [3:0] ext,
                           input logic [4:0] ipl);
      @(negedge clk);
      sw_req = sw; ext_irq = ext; cur_ipl = ipl; check_req = 1'b1;
      @(negedge clk);
      check_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; sw_req = '0; ext_irq = '0; cur_ipl = '0; check_req = 1'b0;
      repeat (3) @(negedge clk);
      // R1: outputs cleared during reset
      chk("R1 trap in reset", 32'(trap), 32'd0);
      chk("R1 isr in reset", 32'(isr), 32'd0);
      chk("R1 intid in reset", 32'(intid), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 trap after release", 32'(trap), 32'd0);

      for (int v = 0; v < NV; v++) begin
         evaluate(VEC[v][62:39], VEC[v][38:35], VEC[v][34:30]);
         chk($sformatf("R6 vector %0d trap", v), 32'(trap), 32'(VEC[v][29]));
         chk($sformatf("R2/R4/R7 vector %0d intid", v), 32'(intid),
             32'(VEC[v][28:24]));
         chk($sformatf("R5/R7 vector %0d isr", v), 32'(isr),
             32'(VEC[v][23:0]));
         @(negedge clk);
         chk($sformatf("R9 vector %0d pulse ends", v), 32'(trap), 32'd0);
      end

      // R8: trapping inputs without a strobe change nothing
      @(negedge clk);
      sw_req = 24'h040000; ext_irq = 4'h8; cur_ipl = 5'd0;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         chk("R8 no strobe trap", 32'(trap), 32'd0);
      end
      chk("R8 no strobe intid", 32'(intid), 32'd15);
      chk("R8 no strobe isr", 32'(isr), 32'h07FFF0);

      // R8 R9: strobe held two cycles gives two evaluations
      sw_req = 24'h000010; ext_irq = 4'h0; cur_ipl = 5'd0; check_req = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R9 first trap", 32'(trap), 32'd1);
      chk("R7 held strobe intid", 32'(intid), 32'd1);
      check_req = 1'b0;
      @(negedge clk);
      chk("R8 second evaluation", 32'(trap), 32'd1);
      @(negedge clk);
      chk("R8 flag cleared", 32'(trap), 32'd0);

      // R1: reset in mid-run clears latched values
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid-run isr", 32'(isr), 32'd0);
      chk("R1 mid-run intid", 32'(intid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end
endmodule